// File: doc/BRIEF.md
# Bidirectional Decade Counter with Asynchronous Preset

This block is a single BCD digit counter. On each rising clock edge, while counting is enabled, it steps through the decimal digits. A direction input chooses the way it moves: upward from 0 to 9 and then back to 0, or downward from 9 to 0 and then back to 9. An active-low preset input bypasses the clock. When it goes low, the stored digit takes the 4-bit load value at once. While it stays low, the load value is taken again at every clock edge. An active-low reset clears the digit and wins over the preset.

A terminal output marks the end of the count in the current direction. It shows 9 when counting up and 0 when counting down, and it follows a change of direction without waiting for a clock. Because the preset acts immediately, a few gates outside the block can turn the count output into the preset control and produce shortened or shifted sequences. The digit that triggers the preset is replaced within the same clock period, so it is never seen at a clock edge. Two examples:
- an OR of the four count bits, with load value 7, gives a divide-by-7 down sequence;
- a NAND of bits 3 and 0, with load value 3, gives a 3-to-8 up sequence.

Top module: `updown_decade_ctr`

## Requirements
- R1: While rst_n is low, count is 0, whatever the clock, the enable or the preset do. The clear takes effect without a clock edge, and reset has priority over load_n.
- R2: With rst_n high, load_n high, cnt_en high and dir_up = 1, each rising clock edge raises count by one for the values 0 to 8.
- R3: When counting up, a count of 9 is followed by 0. Any preset value from 10 to 15 is also followed by 0.
- R4: With dir_up = 0 and counting enabled, a count from 1 to 15 drops by one at each edge, and a count of 0 is followed by 9.
- R5: With cnt_en low and load_n high, count keeps its value across clock edges in both directions.
- R6: A low load_n sets count to load_val without waiting for a clock. While load_n stays low (with load_val steady), count equals load_val whatever cnt_en and dir_up are. After release, counting resumes from the loaded value at the next edge.
- R7: term is 1 exactly when (dir_up = 1 and count = 9) or (dir_up = 0 and count = 0). It changes at once when dir_up changes.
- R8: With load_n driven by the OR of the four count bits, load_val = 7, dir_up = 0 and cnt_en = 1, the values seen at successive clock edges are 7, 6, 5, 4, 3, 2, 1, 7, and so on.
- R9: With load_n driven by the NAND of count bits 3 and 0, load_val = 3, dir_up = 1 and cnt_en = 1, the values seen at successive clock edges run 3, 4, 5, 6, 7, 8, 3, and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| cnt_en | input | 1 | Count enable, active high |
| dir_up | input | 1 | 1 counts upward, 0 counts downward |
| load_n | input | 1 | Asynchronous preset, active low |
| load_val | input | 4 | Value taken on preset |
| count | output | 4 | Current BCD digit |
| term | output | 1 | End-of-count for the current direction |

## Verification
The preset and the clocked count step can act in the same cycle. The bench provokes this by holding load_n low across a rising edge with counting enabled in either direction, and it judges the result by requiring that count still equals load_val after the edge. It also drives reset and preset low together and expects a count of 0. In the feedback arrangements, the count step and the preset fall in the same clock period: the step makes the trigger digit and the preset immediately replaces it. These cases are judged by comparing every sampled value against a step-by-step model of the shortened sequence.

// File: rtl/udc_pkg.sv
`timescale 1ns/1ps
package udc_pkg;
    parameter int unsigned DIGIT_W = 4;

    typedef struct packed {
        logic [DIGIT_W-1:0] value;
    } ctr_state_t;

    localparam ctr_state_t CTR_RESET = '{value: '0};
endpackage

// File: rtl/udc_next.sv
`timescale 1ns/1ps
module udc_next #(
    parameter int unsigned W   = 4,
    parameter int unsigned TOP = 9
) (
    input  logic [W-1:0] cur,
    input  logic         en,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP_V  = W'(TOP);
    localparam logic [W-1:0] ZERO_V = '0;

    always_comb begin
        nxt = cur;
        if (en) begin
            if (up) begin
                // values at or past the top (e.g. a preset of 12) fold to zero
                nxt = (cur >= TOP_V) ? ZERO_V : cur + 1'b1;
            end else begin
                nxt = (cur == ZERO_V) ? TOP_V : cur - 1'b1;
            end
        end
    end
endmodule

// File: rtl/udc_limit.sv
`timescale 1ns/1ps
module udc_limit #(
    parameter int unsigned W   = 4,
    parameter int unsigned TOP = 9
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic         hit
);
    localparam logic [W-1:0] TOP_V = W'(TOP);

    always_comb begin
        if (up) hit = (cur == TOP_V);
        else    hit = (cur == '0);
    end
endmodule

// File: rtl/updown_decade_ctr.sv
`timescale 1ns/1ps
module updown_decade_ctr
    import udc_pkg::*;
#(
    parameter int unsigned TOP_VAL = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en,
    input  logic               dir_up,
    input  logic               load_n,
    input  logic [DIGIT_W-1:0] load_val,
    output logic [DIGIT_W-1:0] count,
    output logic               term
);
    ctr_state_t         st_d, st_q;
    logic [DIGIT_W-1:0] step_nxt;

    udc_next #(.W(DIGIT_W), .TOP(TOP_VAL)) u_next (
        .cur (st_q.value),
        .en  (cnt_en),
        .up  (dir_up),
        .nxt (step_nxt)
    );

    udc_limit #(.W(DIGIT_W), .TOP(TOP_VAL)) u_limit (
        .cur (st_q.value),
        .up  (dir_up),
        .hit (term)
    );

    always_comb begin
        st_d       = st_q;
        st_d.value = step_nxt;
    end

    // clear wins over preset; both act without a clock edge
    always_ff @(posedge clk or negedge rst_n or negedge load_n) begin
        if (!rst_n) begin
            st_q <= CTR_RESET;
        end else if (!load_n) begin
            st_q.value <= load_val;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.value;
endmodule

// File: rtl/udc_checker.sv
`timescale 1ns/1ps
module udc_checker #(
    parameter int unsigned W   = 4,
    parameter int unsigned TOP = 9
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en,
    input logic         dir_up,
    input logic         load_n,
    input logic [W-1:0] load_val,
    input logic [W-1:0] count,
    input logic         term
);
    localparam logic [W-1:0] TOP_V = W'(TOP);

    // a reload in the following cycle (external feedback) is an allowed outcome
    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && dir_up && load_n && count < TOP_V)
        |=> (count == $past(count) + 1'b1) || (count == load_val));

    p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && dir_up && load_n && count >= TOP_V)
        |=> (count == '0) || (count == load_val));

    p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !dir_up && load_n && count != '0)
        |=> (count == $past(count) - 1'b1) || (count == load_val));

    p_down_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !dir_up && load_n && count == '0)
        |=> (count == TOP_V) || (count == load_val));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && load_n)
        |=> (count == $past(count)) || (count == load_val));

    p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n) |=> (load_n || count == $past(load_val)));

    p_term_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_up && count == TOP_V) |-> term);

    p_term_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_up && count == '0) |-> term);

    p_term_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        term |-> (count == (dir_up ? TOP_V : '0)));
endmodule

bind updown_decade_ctr udc_checker #(.W(udc_pkg::DIGIT_W), .TOP(TOP_VAL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .dir_up   (dir_up),
    .load_n   (load_n),
    .load_val (load_val),
    .count    (count),
    .term     (term)
);

// File: tb/test_updown_decade_ctr.sv
`timescale 1ns/1ps
module test_updown_decade_ctr;
    logic       clk = 1'b0;
    logic       rst_n, cnt_en, dir_up, load_n;
    logic [3:0] load_val;
    logic [3:0] count;
    logic       term;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    updown_decade_ctr i_updown_decade_ctr (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_up(dir_up),
        .load_n(load_n), .load_val(load_val), .count(count), .term(term)
    );

    // feedback wrappers: divide-by-7 down (OR gating) and 3..8 up (one NAND)
    logic       wr_rst_n;
    logic [3:0] c7, c6;
    logic       t7, t6, ld7_n, ld6_n;
    assign ld7_n = |c7;
    assign ld6_n = ~(c6[3] & c6[0]);

    updown_decade_ctr i_mod7_ctr (
        .clk(clk), .rst_n(wr_rst_n), .cnt_en(1'b1), .dir_up(1'b0),
        .load_n(ld7_n), .load_val(4'd7), .count(c7), .term(t7)
    );
    updown_decade_ctr i_mod6_ctr (
        .clk(clk), .rst_n(wr_rst_n), .cnt_en(1'b1), .dir_up(1'b1),
        .load_n(ld6_n), .load_val(4'd3), .count(c6), .term(t6)
    );

    // vector: [11] en [10] up [9] load_n [8:5] load_val [4:1] exp count [0] exp term
    localparam int NV = 28;
    localparam logic [11:0] VEC [NV] = '{
        {3'b111, 4'd0,  4'd1,  1'b0}, {3'b111, 4'd0, 4'd2, 1'b0},
        {3'b111, 4'd0,  4'd3,  1'b0}, {3'b111, 4'd0, 4'd4, 1'b0},
        {3'b111, 4'd0,  4'd5,  1'b0}, {3'b111, 4'd0, 4'd6, 1'b0},
        {3'b111, 4'd0,  4'd7,  1'b0}, {3'b111, 4'd0, 4'd8, 1'b0},
        {3'b111, 4'd0,  4'd9,  1'b1}, {3'b111, 4'd0, 4'd0, 1'b0},
        {3'b101, 4'd0,  4'd9,  1'b0}, {3'b101, 4'd0, 4'd8, 1'b0},
        {3'b001, 4'd0,  4'd8,  1'b0}, {3'b011, 4'd0, 4'd8, 1'b0},
        {3'b110, 4'd2,  4'd2,  1'b0}, {3'b100, 4'd2, 4'd2, 1'b0},
        {3'b111, 4'd0,  4'd3,  1'b0}, {3'b101, 4'd0, 4'd2, 1'b0},
        {3'b101, 4'd0,  4'd1,  1'b0}, {3'b101, 4'd0, 4'd0, 1'b1},
        {3'b011, 4'd0,  4'd0,  1'b0}, {3'b110, 4'd12, 4'd12, 1'b0},
        {3'b111, 4'd0,  4'd0,  1'b0}, {3'b000, 4'd13, 4'd13, 1'b0},
        {3'b101, 4'd0,  4'd12, 1'b0}, {3'b101, 4'd0, 4'd11, 1'b0},
        {3'b110, 4'd9,  4'd9,  1'b1}, {3'b011, 4'd0, 4'd9, 1'b1}
    };
    localparam string VTAG [NV] = '{
        "R2", "R2", "R2", "R2", "R2", "R2", "R2", "R2", "R7", "R3",
        "R4", "R4", "R5", "R5", "R6", "R6", "R6", "R4", "R4", "R7",
        "R7", "R6", "R3", "R6", "R4", "R4", "R6", "R5"
    };

    task automatic chk(input string req, input logic [3:0] act_c, input logic [3:0] exp_c,
                       input logic act_t, input logic exp_t);
        total++;
        if (act_c !== exp_c || act_t !== exp_t) begin
            bad++;
            $display("FAIL %s: count=%0d term=%0b expected count=%0d term=%0b",
                     req, act_c, act_t, exp_c, exp_t);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] m7, m6;
        rst_n = 1'b0; wr_rst_n = 1'b0;
        cnt_en = 1'b0; dir_up = 1'b1; load_n = 1'b1; load_val = 4'd0;
        #3;
        chk("R1 reset state", count, 4'd0, term, 1'b0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cnt_en   = VEC[i][11];
            dir_up   = VEC[i][10];
            load_val = VEC[i][8:5];
            load_n   = VEC[i][9];
            @(posedge clk);
            #1;
            chk(VTAG[i], count, VEC[i][4:1], term, VEC[i][0]);
            @(negedge clk);
        end

        // R6: preset acts before any clock edge, and holds across one
        cnt_en = 1'b0; dir_up = 1'b1;
        load_val = 4'd5; load_n = 1'b0;
        #1;
        chk("R6 async preset", count, 4'd5, term, 1'b0);
        @(posedge clk); #1;
        chk("R6 preset held over edge", count, 4'd5, term, 1'b0);
        @(negedge clk);
        load_n = 1'b1; load_val = 4'd0; cnt_en = 1'b1;
        @(posedge clk); #1;
        chk("R6 resume after preset", count, 4'd6, term, 1'b0);

        // R7: term follows direction without a clock
        @(negedge clk);
        cnt_en = 1'b0; load_val = 4'd0; load_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        load_n = 1'b1; dir_up = 1'b1;
        #1;
        chk("R7 term up at 0", count, 4'd0, term, 1'b0);
        dir_up = 1'b0;
        #1;
        chk("R7 term down at 0", count, 4'd0, term, 1'b1);

        // R1: asynchronous clear, and priority over preset
        @(negedge clk);
        cnt_en = 1'b1; dir_up = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear", count, 4'd0, term, 1'b0);
        load_val = 4'd6; load_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 clear beats preset", count, 4'd0, term, 1'b0);
        @(negedge clk);
        load_n = 1'b1; rst_n = 1'b1;

        // R8 and R9: feedback wrappers against a step model
        wr_rst_n = 1'b1;
        m7 = 4'd0; m6 = 4'd0;
        for (int k = 0; k < 14; k++) begin
            @(posedge clk); #1;
            m7 = (m7 <= 4'd1) ? 4'd7 : m7 - 4'd1;
            m6 = (m6 == 4'd8) ? 4'd3 : m6 + 4'd1;
            chk("R8 divide-by-7 down", c7, m7, 1'b0, 1'b0);
            chk("R9 3..8 up", c6, m6, 1'b0, 1'b0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule